// File: doc/BRIEF.md
# Pseudo-Random Pattern Test Engine

This block is a per-channel built-in test engine for a parallel transmit/receive datapath. A pattern source on the transmit side replaces ordinary transmit words with a seven-stage maximal-length pseudo-random sequence (polynomial x^7 + x^6 + 1). Ten bits of the sequence go out on each clock. A pattern checker on the receive side locks onto the incoming words and counts every clock whose word differs from its prediction.

Software drives the engine through a small register port. It clears the normal-operation enables, turns on the source, reads the error counter once to empty it, and then turns on the checker. Two saturating error counters exist. A rate-mode input chooses which one receives errors: one counter serves the fast line rate and the other the slow rate. Reading a counter empties it. The read does not stop the pattern, and the checker does not have to relock.

Top module: `prbs_test_engine`

## Requirements
- R1: After reset the control register (address 16) reads 0x1004, which means the normal-operation enable (bit 12) and the alignment-detect enable (bit 2) are set and both test enables are clear. Both error counters (addresses 29 and 31) read 0.
- R2: A write to address 16 keeps only bits 12, 7, 6 and 2. Every other bit reads back as 0, and the new value governs the engine from the next clock. The read data of any address appears on `reg_rdata_o` in the cycle after the read strobe. An unmapped address reads as 0.
- R3: The pattern source is active only while bit 6 is 1 and bits 12 and 2 are both 0. While it is active, `tx_data_o` carries the sequence in which each bit equals the XOR of the bits 7 and 6 positions earlier. Bit 9 of a word is the earliest bit. The first word after reset comes from an all-ones history, and the source advances by one word per clock.
- R4: While the source is inactive, `tx_data_o` equals `tx_data_i` and the source keeps its position, so it resumes the sequence where it stopped.
- R5: The checker is active only while bit 7 is 1 and bits 12 and 2 are both 0. In its first active clock it loads its history from `rx_data_i[6:0]` (bit 0 is the latest) and counts nothing. In each later active clock it counts exactly one error if any bit of `rx_data_i` differs from its predicted word, and it then advances its own prediction.
- R6: When `rate_mode_i` is 1, errors go to the counter at address 29. When it is 0, they go to the counter at address 31. The unselected counter is left unchanged.
- R7: A read of address 29 or 31 returns the counter's value and empties it. If an error is counted in the same clock as the read, the counter holds 1 afterwards. The read does not disturb the source or the checker's lock.
- R8: The counters are 16 bits wide. At 0xFFFF they stay at 0xFFFF and do not wrap.
- R9: When the checker becomes inactive it loses lock, and the counters keep their values until read. When it is enabled again it reseeds before it counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_mode_i | input | 1 | 1 = fast-rate counter, 0 = slow-rate counter |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data |
| tx_data_i | input | 10 | Normal transmit word |
| tx_data_o | output | 10 | Transmit word to the line |
| rx_data_i | input | 10 | Received word |

## Verification
Several properties are checked on every clock. A counter never wraps past all ones, and it holds its value when it has neither an error nor a read. A read that coincides with an error leaves exactly 1. Errors reach only the counter that the rate mode selects. The source's history never becomes all zeros and does not move while the source is idle. The checker is locked after any active clock and unlocked after any inactive one, and it never reports an error before lock. Some behaviour appears only in the bench's scenarios. These include the exact bit sequence on the transmit bus and its resumption after a pause, the lock taken from a looped-back stream, the read-clears-without-relock behaviour over many clocks, and saturation after more than 65535 injected errors.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int unsigned PAT_W    = 10;
    localparam int unsigned HIST_W   = 7;
    localparam int unsigned TAP_OLD  = 6;
    localparam int unsigned TAP_NEW  = 5;
    localparam int unsigned REG_AW   = 5;
    localparam int unsigned REG_DW   = 16;

    localparam logic [REG_AW-1:0] ADDR_CTRL   = 5'd16;
    localparam logic [REG_AW-1:0] ADDR_ERR_HI = 5'd29;
    localparam logic [REG_AW-1:0] ADDR_ERR_LO = 5'd31;

    localparam int unsigned BIT_NORMAL = 12;
    localparam int unsigned BIT_CHK    = 7;
    localparam int unsigned BIT_GEN    = 6;
    localparam int unsigned BIT_ALIGN  = 2;

    localparam logic [REG_DW-1:0] CTRL_RESET = 16'h1004;
    localparam logic [REG_DW-1:0] CTRL_KEEP  = 16'h10C4;

    localparam logic [HIST_W-1:0] HIST_SEED = '1;

    typedef struct packed {
        logic normal_on;
        logic chk_on;
        logic gen_on;
        logic align_on;
    } test_ctrl_t;

    typedef enum logic {
        VF_HUNT  = 1'b0,
        VF_TRACK = 1'b1
    } vf_state_e;

    typedef struct packed {
        logic [PAT_W-1:0]  word;
        logic [HIST_W-1:0] next;
    } pat_step_t;

    // Produce one bus word from a history and return the history after it.
    function automatic pat_step_t pat_advance(input logic [HIST_W-1:0] hist);
        pat_step_t        res;
        logic [HIST_W-1:0] h;
        logic             b;
        h = hist;
        res.word = '0;
        for (int i = PAT_W - 1; i >= 0; i--) begin
            b = h[TAP_OLD] ^ h[TAP_NEW];
            res.word[i] = b;
            h = {h[HIST_W-2:0], b};
        end
        res.next = h;
        return res;
    endfunction

    function automatic test_ctrl_t decode_ctrl(input logic [REG_DW-1:0] r);
        test_ctrl_t c;
        c.normal_on = r[BIT_NORMAL];
        c.chk_on    = r[BIT_CHK];
        c.gen_on    = r[BIT_GEN];
        c.align_on  = r[BIT_ALIGN];
        return c;
    endfunction

endpackage

// File: rtl/prbs_err_counter.sv
module prbs_err_counter
    import prbs_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= inc_i ? CNT_ONE : '0;
        end else if (inc_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign count_o = cnt_q;

    a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && inc_i && !clr_i) |=> cnt_q == CNT_MAX);

    a_r7_clear_keeps_event: assert property (@(posedge clk) disable iff (rst)
        (clr_i && inc_i) |=> cnt_q == CNT_ONE);

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !inc_i) |=> cnt_q == '0);

    a_r9_hold_when_quiet: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !inc_i) |=> $stable(cnt_q));

endmodule

// File: rtl/prbs_ctrl_regs.sv
module prbs_ctrl_regs
    import prbs_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [REG_DW-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_hi_i,
    input  logic [CNT_W-1:0]  cnt_lo_i,
    output test_ctrl_t        ctrl_o,
    output logic              clr_hi_o,
    output logic              clr_lo_o,
    output logic [REG_DW-1:0] rdata_o
);

    logic [REG_DW-1:0] ctrl_q;
    logic [REG_DW-1:0] rdata_q;
    logic [REG_DW-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_i && addr_i == ADDR_CTRL) begin
            ctrl_q <= wdata_i & CTRL_KEEP;
        end
    end

    always_comb begin
        unique case (addr_i)
            ADDR_CTRL:   rd_mux = ctrl_q;
            ADDR_ERR_HI: rd_mux = REG_DW'(cnt_hi_i);
            ADDR_ERR_LO: rd_mux = REG_DW'(cnt_lo_i);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= rd_mux;
        end
    end

    assign ctrl_o   = decode_ctrl(ctrl_q);
    assign clr_hi_o = rd_i && (addr_i == ADDR_ERR_HI);
    assign clr_lo_o = rd_i && (addr_i == ADDR_ERR_LO);
    assign rdata_o  = rdata_q;

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q & ~CTRL_KEEP) == '0);

    a_r7_one_clear: assert property (@(posedge clk) disable iff (rst)
        !(clr_hi_o && clr_lo_o));

endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
    import prbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    output logic [PAT_W-1:0] word_o
);

    logic [HIST_W-1:0] hist_q;
    pat_step_t         step;

    assign step = pat_advance(hist_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= HIST_SEED;
        end else if (active_i) begin
            hist_q <= step.next;
        end
    end

    assign word_o = step.word;

    a_r4_pause_holds: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> $stable(hist_q));

    a_r3_never_zero: assert property (@(posedge clk) disable iff (rst)
        hist_q != '0);

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
    import prbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic [PAT_W-1:0] rx_i,
    output logic             err_o
);

    vf_state_e         state_q;
    logic [HIST_W-1:0] hist_q;
    pat_step_t         pred;
    logic              tracking;

    assign pred     = pat_advance(hist_q);
    assign tracking = (state_q == VF_TRACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= VF_HUNT;
            hist_q  <= HIST_SEED;
        end else if (!active_i) begin
            state_q <= VF_HUNT;
        end else if (!tracking) begin
            state_q <= VF_TRACK;
            hist_q  <= rx_i[HIST_W-1:0];
        end else begin
            hist_q  <= pred.next;
        end
    end

    assign err_o = active_i && tracking && (pred.word != rx_i);

    a_r9_unlock_when_off: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> state_q == VF_HUNT);

    a_r5_lock_when_on: assert property (@(posedge clk) disable iff (rst)
        active_i |=> state_q == VF_TRACK);

    a_r5_no_count_in_hunt: assert property (@(posedge clk) disable iff (rst)
        (state_q == VF_HUNT) |-> !err_o);

endmodule

// File: rtl/prbs_test_engine.sv
module prbs_test_engine
    import prbs_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_mode_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    input  logic [PAT_W-1:0]  tx_data_i,
    output logic [PAT_W-1:0]  tx_data_o,
    input  logic [PAT_W-1:0]  rx_data_i
);

    localparam int unsigned N_CNT  = 2;
    localparam int unsigned IDX_HI = 0;
    localparam int unsigned IDX_LO = 1;

    test_ctrl_t       ctrl;
    logic             test_mode;
    logic             gen_active;
    logic             chk_active;
    logic             err;
    logic [PAT_W-1:0] gen_word;
    logic [N_CNT-1:0] inc_v;
    logic [N_CNT-1:0] clr_v;
    logic [CNT_W-1:0] cnt_v [N_CNT];

    assign test_mode  = !ctrl.normal_on && !ctrl.align_on;
    assign gen_active = test_mode && ctrl.gen_on;
    assign chk_active = test_mode && ctrl.chk_on;

    prbs_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (reg_wr_i),
        .rd_i     (reg_rd_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .cnt_hi_i (cnt_v[IDX_HI]),
        .cnt_lo_i (cnt_v[IDX_LO]),
        .ctrl_o   (ctrl),
        .clr_hi_o (clr_v[IDX_HI]),
        .clr_lo_o (clr_v[IDX_LO]),
        .rdata_o  (reg_rdata_o)
    );

    prbs_gen u_gen (
        .clk      (clk),
        .rst      (rst),
        .active_i (gen_active),
        .word_o   (gen_word)
    );

    assign tx_data_o = gen_active ? gen_word : tx_data_i;

    prbs_chk u_chk (
        .clk      (clk),
        .rst      (rst),
        .active_i (chk_active),
        .rx_i     (rx_data_i),
        .err_o    (err)
    );

    assign inc_v[IDX_HI] = err && rate_mode_i;
    assign inc_v[IDX_LO] = err && !rate_mode_i;

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        prbs_err_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .inc_i   (inc_v[g]),
            .clr_i   (clr_v[g]),
            .count_o (cnt_v[g])
        );
    end

    a_r6_fast_leaves_slow: assert property (@(posedge clk) disable iff (rst)
        (err && rate_mode_i && !clr_v[IDX_LO]) |=> $stable(cnt_v[IDX_LO]));

    a_r6_slow_leaves_fast: assert property (@(posedge clk) disable iff (rst)
        (err && !rate_mode_i && !clr_v[IDX_HI]) |=> $stable(cnt_v[IDX_HI]));

endmodule

// File: tb/prbs_test_engine_tb_top.sv
module prbs_test_engine_tb_top;

    localparam int CLK_PERIOD  = 10;
    localparam int WATCHDOG_CY = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rate_mode = 1'b1;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [9:0]  tx_in = '0;
    logic [9:0]  tx_out;
    logic [9:0]  inj_mask = '0;
    logic [9:0]  rx_in;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // model state
    logic [15:0] m_ctrl;
    logic [6:0]  m_g;
    logic [6:0]  m_c;
    logic        m_lock;
    logic [15:0] m_hi;
    logic [15:0] m_lo;
    logic [15:0] m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rx_in = tx_out ^ inj_mask;

    prbs_test_engine dut_i (
        .clk         (clk),
        .rst         (rst),
        .rate_mode_i (rate_mode),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .tx_data_i   (tx_in),
        .tx_data_o   (tx_out),
        .rx_data_i   (rx_in)
    );

    // Bit stream b[k] = b[k-7] ^ b[k-6]; history holds the seven latest bits.
    function automatic logic [9:0] ref_word(input logic [6:0] h);
        logic [16:0] b;
        logic [9:0]  w;
        for (int k = 0; k < 7; k++) b[k] = h[6-k];
        for (int k = 7; k < 17; k++) b[k] = b[k-7] ^ b[k-6];
        for (int j = 0; j < 10; j++) w[9-j] = b[7+j];
        return w;
    endfunction

    function automatic logic [6:0] ref_next(input logic [6:0] h);
        logic [16:0] b;
        logic [6:0]  n;
        for (int k = 0; k < 7; k++) b[k] = h[6-k];
        for (int k = 7; k < 17; k++) b[k] = b[k-7] ^ b[k-6];
        for (int i = 0; i < 7; i++) n[6-i] = b[10+i];
        return n;
    endfunction

    function automatic bit gen_on(input logic [15:0] c);
        return c[6] && !c[12] && !c[2];
    endfunction

    function automatic bit chk_on(input logic [15:0] c);
        return c[7] && !c[12] && !c[2];
    endfunction

    function automatic logic [15:0] sat_inc(input logic [15:0] v);
        return (v == 16'hFFFF) ? v : v + 16'd1;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl  = 16'h1004;
        m_g     = 7'h7F;
        m_c     = 7'h7F;
        m_lock  = 1'b0;
        m_hi    = '0;
        m_lo    = '0;
        m_rdata = '0;
    endtask

    // Applies the effect of one rising edge using the pre-edge inputs.
    task automatic model_edge();
        logic [9:0] tx_m;
        logic [9:0] rx_m;
        bit         e;
        bit         ehi;
        bit         elo;
        tx_m = gen_on(m_ctrl) ? ref_word(m_g) : tx_in;
        rx_m = tx_m ^ inj_mask;
        e = 0;
        if (!chk_on(m_ctrl)) begin
            m_lock = 1'b0;
        end else if (!m_lock) begin
            m_lock = 1'b1;
            m_c    = rx_m[6:0];
        end else begin
            e   = (ref_word(m_c) != rx_m);
            m_c = ref_next(m_c);
        end
        ehi = e && rate_mode;
        elo = e && !rate_mode;
        if (rd) begin
            case (addr)
                5'd16:   m_rdata = m_ctrl;
                5'd29:   m_rdata = m_hi;
                5'd31:   m_rdata = m_lo;
                default: m_rdata = '0;
            endcase
        end
        if (rd && addr == 5'd29) m_hi = ehi ? 16'd1 : 16'd0;
        else if (ehi)            m_hi = sat_inc(m_hi);
        if (rd && addr == 5'd31) m_lo = elo ? 16'd1 : 16'd0;
        else if (elo)            m_lo = sat_inc(m_lo);
        if (gen_on(m_ctrl)) m_g = ref_next(m_g);
        if (wr && addr == 5'd16) m_ctrl = wdata & 16'h10C4;
    endtask

    task automatic cyc(input string tag);
        bit was_rd;
        @(posedge clk);
        was_rd = rd;
        model_edge();
        @(negedge clk);
        if (was_rd) check(tag, rdata, m_rdata);
        wr    = 1'b0;
        rd    = 1'b0;
        tx_in = 10'($urandom);
        #1;
        check(gen_on(m_ctrl) ? "R3 pattern" : "R4 passthrough",
              {6'd0, tx_out}, {6'd0, gen_on(m_ctrl) ? ref_word(m_g) : tx_in});
    endtask

    task automatic rd_reg(input logic [4:0] a, input string tag);
        rd = 1'b1; addr = a;
        cyc(tag);
    endtask

    task automatic wr_reg(input logic [15:0] d, input string tag);
        wr = 1'b1; addr = 5'd16; wdata = d;
        cyc(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CY) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd_reg(5'd16, "R1 ctrl reset");
        check("R1 ctrl literal", rdata, 16'h1004);
        rd_reg(5'd29, "R1 fast counter reset");
        rd_reg(5'd31, "R1 slow counter reset");

        // R2: reserved bits, unmapped address; R4: source blocked by normal enable
        wr_reg(16'hFFFF, "R2 write all");
        rd_reg(5'd16, "R2 readback mask");
        check("R2 mask literal", rdata, 16'h10C4);
        rd_reg(5'd3, "R2 unmapped");
        repeat (4) cyc("R4 blocked");
        wr_reg(16'h0044, "R4 align still on");
        repeat (4) cyc("R4 blocked by align");

        // R3: start source, check first words against a fixed history
        wr_reg(16'h0040, "R3 gen on");
        repeat (20) cyc("R3 run");
        // R4: pause then resume
        wr_reg(16'h0000, "R4 pause");
        repeat (6) cyc("R4 paused");
        wr_reg(16'h0040, "R4 resume");
        repeat (6) cyc("R3 resumed");

        // Recommended order: clear counter, enable checker
        rate_mode = 1'b1;
        rd_reg(5'd29, "R7 pre-clear");
        wr_reg(16'h00C0, "R5 chk on");
        cyc("R5 seed cycle");
        repeat (10) cyc("R5 clean");
        rd_reg(5'd29, "R5 no errors when clean");
        check("R5 zero literal", rdata, 16'h0000);
        inj_mask = 10'h200; cyc("R5 one error");
        inj_mask = 10'h000; repeat (3) cyc("R5 after error");
        inj_mask = 10'h3FF; cyc("R5 all bits wrong counts once");
        inj_mask = 10'h000;
        rd_reg(5'd29, "R5 two errors");
        check("R5 two literal", rdata, 16'd2);

        // R7: read during error, test continues without relock
        inj_mask = 10'h001; repeat (5) cyc("R7 errors");
        rd = 1'b1; addr = 5'd29; cyc("R7 read with error");
        inj_mask = 10'h000;
        rd_reg(5'd29, "R7 coincident error kept");
        check("R7 one literal", rdata, 16'd1);
        inj_mask = 10'h010; repeat (3) cyc("R7 still locked");
        inj_mask = 10'h000;
        rd_reg(5'd29, "R7 counting after read");

        // R6: route to slow counter
        rate_mode = 1'b0;
        inj_mask = 10'h080; repeat (7) cyc("R6 slow errors");
        inj_mask = 10'h000;
        rd_reg(5'd29, "R6 fast untouched");
        rd_reg(5'd31, "R6 slow counted");
        check("R6 seven literal", rdata, 16'd7);

        // R9: disable checker, counters hold, relock
        inj_mask = 10'h004; repeat (4) cyc("R9 errors before off");
        wr_reg(16'h0040, "R9 chk off");
        inj_mask = 10'h2AA; repeat (8) cyc("R9 off ignores");
        inj_mask = 10'h000;
        rd_reg(5'd31, "R9 held value");
        wr_reg(16'h00C0, "R9 chk on again");
        inj_mask = 10'h155; cyc("R9 reseed from corrupt word");
        inj_mask = 10'h000; repeat (4) cyc("R9 after reseed");
        rd_reg(5'd31, "R9 reseed counts");

        // R8: saturation
        rate_mode = 1'b1;
        wr_reg(16'h00C0, "R8 setup");
        rd_reg(5'd29, "R8 clear");
        inj_mask = 10'h001;
        repeat (65600) cyc("R8 fill");
        inj_mask = 10'h000;
        rd_reg(5'd29, "R8 saturated");
        check("R8 max literal", rdata, 16'hFFFF);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            r = $urandom;
            if (r % 16 == 0) begin
                wr = 1'b1; addr = 5'd16;
                wdata = 16'($urandom);
                wdata[12] = ($urandom % 6 == 0);
                wdata[2]  = ($urandom % 6 == 0);
            end
            if (r % 9 == 1) begin
                rd = 1'b1;
                case ($urandom % 4)
                    0:       addr = 5'd16;
                    1:       addr = 5'd29;
                    2:       addr = 5'd31;
                    default: addr = 5'd5;
                endcase
            end
            if ((r >> 8) % 50 == 0) rate_mode = ~rate_mode;
            inj_mask = ((r >> 16) % 10 == 0) ? 10'($urandom) : 10'h000;
            cyc("R7 random mix");
        end
        inj_mask = 10'h000;
        rd_reg(5'd29, "R6 final fast");
        rd_reg(5'd31, "R6 final slow");
        rd_reg(5'd16, "R2 final ctrl");
        finish_run();
    end

endmodule